// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the exception-control slice of a small pipelined core that has two interrupt request lines: a normal request and a fast request. At each instruction boundary (marked by a completion strobe) it decides whether a request is taken. On entry it stores the current status word and program counter into a saved-register bank for the mode being entered. It produces a new status word with the mode field and mask bits updated, and it points fetch at a fixed vector. The instruction that was already prefetched is dropped, because fetch is redirected.

When the core issues a return strobe, the block reads the bank of the active exception mode. It restores the status word from that bank and resumes fetch at the saved link value minus one word. The counter that the core presents already runs two words ahead of the executing instruction, and this adjustment corrects for that. The core drives the current PC and status word in, and it applies `next_pc_o` and `psr_o` in the cycle after `redirect_o` pulses.

Top module: `exc_seq`

## Requirements
- R1: After reset, `redirect_o` is 0, `next_pc_o` is 0, `psr_o` is 0xD0 (user mode 5'b10000 in bits [4:0], I bit [7] and F bit [6] both 1), and all four saved-register outputs are 0.
- R2: When `instr_done_i` is 1, `ret_i` is 0, `irq_req_i` is 1, I (`psr_i[7]`) is 0, and no fast request wins, a normal entry takes place. On the next cycle `lr_norm_o` equals the sampled `pc_i` and `spsr_norm_o` equals the sampled `psr_i`.
- R3: On a normal entry, `psr_o` equals `psr_i` with bits [4:0] set to 5'b10010, bit 7 set to 1, and bit 6 and all other bits unchanged.
- R4: One cycle after an accepted request, `redirect_o` is 1 for exactly one cycle. `next_pc_o` is 0x18 for a normal entry and 0x1C for a fast entry.
- R5: When `instr_done_i` is 1, `ret_i` is 0, `fiq_req_i` is 1 and F (`psr_i[6]`) is 0, a fast entry takes place. `lr_fast_o` and `spsr_fast_o` capture `pc_i` and `psr_i`. `psr_o` equals `psr_i` with bits [4:0] set to 5'b10001 and bits 7 and 6 set to 1.
- R6: If both requests are unmasked at the same boundary, the fast request is taken. If F is 1, an unmasked normal request is taken instead.
- R7: A request whose mask bit is 1, or a request raised while `instr_done_i` is 0, is not taken. `redirect_o` stays 0, and the outputs and banks keep their values.
- R8: A return strobe while `psr_i[4:0]` is 5'b10010 gives `redirect_o`=1, `next_pc_o` = `lr_norm_o` − 4 and `psr_o` = `spsr_norm_o` on the next cycle.
- R9: A return strobe while `psr_i[4:0]` is 5'b10001 gives `next_pc_o` = `lr_fast_o` − 4 and `psr_o` = `spsr_fast_o`.
- R10: A return strobe in user mode (or in any mode other than the two exception modes) is ignored. `redirect_o` stays 0 and `next_pc_o`, `psr_o` and both banks keep their values.
- R11: When `ret_i` and `instr_done_i` are both 1, the return is serviced and no request is taken in that cycle.
- R12: An entry writes only the bank of the mode being entered, and a return writes neither bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 1 | Normal interrupt request |
| fiq_req_i | input | 1 | Fast interrupt request |
| instr_done_i | input | 1 | Current instruction completed (boundary strobe) |
| ret_i | input | 1 | Exception return strobe |
| pc_i | input | AW | Current PC (instruction address + 8) |
| psr_i | input | PW | Current status word |
| next_pc_o | output | AW | Redirect target for fetch |
| psr_o | output | PW | Status word to install |
| redirect_o | output | 1 | One-cycle pulse: apply next_pc_o and psr_o |
| lr_norm_o | output | AW | Saved PC of the normal-interrupt bank |
| spsr_norm_o | output | PW | Saved status of the normal-interrupt bank |
| lr_fast_o | output | AW | Saved PC of the fast-interrupt bank |
| spsr_fast_o | output | PW | Saved status of the fast-interrupt bank |

## Verification
The hardest case to reach is the collision where a return, a completion strobe and an unmasked fast request all arrive in one cycle while the core sits in fast mode. Here the bank that is being read must not also be overwritten. Ordinary traffic almost never lines these up. The bench therefore drives this exact combination directly after it has filled the fast bank with a known link value. A long run of random boundary, request, return and status patterns, checked on every cycle against a behavioural model, then covers the priority and masking mixes.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam logic [4:0] MODE_USR = 5'b10000;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam int         I_POS    = 7;
   localparam int         F_POS    = 6;
   localparam int         NBANK    = 2;

   typedef enum logic [1:0] {EV_NONE, EV_IRQ, EV_FIQ, EV_RET} ev_e;

   // bank index: 0 = normal, 1 = fast
   function automatic logic [7:0] enter_low(input logic [7:0] lo,
                                            input logic [4:0] mode,
                                            input logic       mask_f);
      logic [7:0] r;
      r        = lo;
      r[4:0]   = mode;
      r[I_POS] = 1'b1;
      if (mask_f) r[F_POS] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
(
   input  logic       irq_req_i,
   input  logic       fiq_req_i,
   input  logic       instr_done_i,
   input  logic       ret_i,
   input  logic [4:0] mode_i,
   input  logic       i_mask_i,
   input  logic       f_mask_i,
   output ev_e        ev_o,
   output logic       ret_bank_o
);
   logic in_fiq, in_irq;

   always_comb begin
      in_fiq     = (mode_i == MODE_FIQ);
      in_irq     = (mode_i == MODE_IRQ);
      ret_bank_o = in_fiq;
      ev_o       = EV_NONE;
      if (ret_i) begin
         if (in_fiq || in_irq) ev_o = EV_RET;
      end else if (instr_done_i) begin
         if (fiq_req_i && !f_mask_i)      ev_o = EV_FIQ;
         else if (irq_req_i && !i_mask_i) ev_o = EV_IRQ;
      end
   end
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
   parameter int AW = 32,
   parameter int PW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [AW-1:0] lr_d_i,
   input  logic [PW-1:0] sp_d_i,
   output logic [AW-1:0] lr_q_o,
   output logic [PW-1:0] sp_q_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lr_q_o <= '0;
         sp_q_o <= '0;
      end else if (we_i) begin
         lr_q_o <= lr_d_i;
         sp_q_o <= sp_d_i;
      end
   end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int          PW       = 32,
   parameter logic [AW-1:0] VEC_BASE = '0,
   parameter int          IRQ_OFF  = 'h18,
   parameter int          FIQ_OFF  = 'h1C,
   parameter int          RET_ADJ  = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          irq_req_i,
   input  logic          fiq_req_i,
   input  logic          instr_done_i,
   input  logic          ret_i,
   input  logic [AW-1:0] pc_i,
   input  logic [PW-1:0] psr_i,
   output logic [AW-1:0] next_pc_o,
   output logic [PW-1:0] psr_o,
   output logic          redirect_o,
   output logic [AW-1:0] lr_norm_o,
   output logic [PW-1:0] spsr_norm_o,
   output logic [AW-1:0] lr_fast_o,
   output logic [PW-1:0] spsr_fast_o
);
   localparam logic [AW-1:0] IRQ_VEC = VEC_BASE + AW'(IRQ_OFF);
   localparam logic [AW-1:0] FIQ_VEC = VEC_BASE + AW'(FIQ_OFF);
   localparam logic [PW-1:0] PSR_RST = PW'({1'b1, 1'b1, 1'b0, MODE_USR});

   initial begin
      assert (AW >= 8) else $error("exc_seq: AW below 8");
      assert (PW >= 8) else $error("exc_seq: PW below 8");
      assert (FIQ_OFF != IRQ_OFF) else $error("exc_seq: vectors collide");
   end

   ev_e           ev;
   logic          ret_bank;
   logic [AW-1:0] lr_q [NBANK];
   logic [PW-1:0] sp_q [NBANK];
   logic [PW-1:0] psr_nxt;
   logic [AW-1:0] pc_nxt;

   exc_arbiter u_arb (
      .irq_req_i    (irq_req_i),
      .fiq_req_i    (fiq_req_i),
      .instr_done_i (instr_done_i),
      .ret_i        (ret_i),
      .mode_i       (psr_i[4:0]),
      .i_mask_i     (psr_i[I_POS]),
      .f_mask_i     (psr_i[F_POS]),
      .ev_o         (ev),
      .ret_bank_o   (ret_bank)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam ev_e OWN_EV = (b == 0) ? EV_IRQ : EV_FIQ;
      exc_bank #(.AW(AW), .PW(PW)) u_bank (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .we_i   (ev == OWN_EV),
         .lr_d_i (pc_i),
         .sp_d_i (psr_i),
         .lr_q_o (lr_q[b]),
         .sp_q_o (sp_q[b])
      );
   end

   always_comb begin
      pc_nxt  = next_pc_o;
      psr_nxt = psr_o;
      unique case (ev)
         EV_IRQ: begin
            pc_nxt  = IRQ_VEC;
            psr_nxt = {psr_i[PW-1:8], enter_low(psr_i[7:0], MODE_IRQ, 1'b0)};
         end
         EV_FIQ: begin
            pc_nxt  = FIQ_VEC;
            psr_nxt = {psr_i[PW-1:8], enter_low(psr_i[7:0], MODE_FIQ, 1'b1)};
         end
         EV_RET: begin
            pc_nxt  = lr_q[ret_bank] - AW'(RET_ADJ);
            psr_nxt = sp_q[ret_bank];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         next_pc_o  <= '0;
         psr_o      <= PSR_RST;
         redirect_o <= 1'b0;
      end else begin
         next_pc_o  <= pc_nxt;
         psr_o      <= psr_nxt;
         redirect_o <= (ev != EV_NONE);
      end
   end

   assign lr_norm_o   = lr_q[0];
   assign spsr_norm_o = sp_q[0];
   assign lr_fast_o   = lr_q[1];
   assign spsr_fast_o = sp_q[1];
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
   import exc_pkg::*;
#(
   parameter int AW = 32,
   parameter int PW = 32,
   parameter logic [AW-1:0] IRQ_VEC = 'h18,
   parameter logic [AW-1:0] FIQ_VEC = 'h1C
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          irq_req_i,
   input logic          fiq_req_i,
   input logic          instr_done_i,
   input logic          ret_i,
   input logic [AW-1:0] pc_i,
   input logic [PW-1:0] psr_i,
   input logic [AW-1:0] next_pc_o,
   input logic [PW-1:0] psr_o,
   input logic          redirect_o,
   input logic [AW-1:0] lr_norm_o,
   input logic [PW-1:0] spsr_norm_o,
   input logic [AW-1:0] lr_fast_o,
   input logic [PW-1:0] spsr_fast_o
);
   logic take_fiq, take_irq, blocked;
   assign take_fiq = instr_done_i && !ret_i && fiq_req_i && !psr_i[F_POS];
   assign take_irq = instr_done_i && !ret_i && irq_req_i && !psr_i[I_POS] && !take_fiq;
   assign blocked  = !ret_i && !take_fiq && !take_irq;

   p_irq_save_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_irq |=> lr_norm_o == $past(pc_i) && spsr_norm_o == $past(psr_i));

   p_irq_psr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_irq |=> psr_o[4:0] == MODE_IRQ && psr_o[I_POS] && psr_o[F_POS] == $past(psr_i[F_POS]));

   p_irq_vec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_irq |=> redirect_o && next_pc_o == IRQ_VEC);

   p_fiq_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_fiq |=> redirect_o && next_pc_o == FIQ_VEC && psr_o[I_POS] && psr_o[F_POS]
                   && lr_fast_o == $past(pc_i) && spsr_fast_o == $past(psr_i));

   p_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blocked |=> !redirect_o && $stable(next_pc_o) && $stable(psr_o));

   p_ret_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i && psr_i[4:0] == MODE_IRQ |=> redirect_o && next_pc_o == $past(lr_norm_o) - AW'(4)
                                          && psr_o == $past(spsr_norm_o));

   p_ret_user_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i && psr_i[4:0] == MODE_USR |=> !redirect_o && $stable(psr_o) && $stable(next_pc_o));

   p_ret_banks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_i |=> $stable(lr_fast_o) && $stable(lr_norm_o) && $stable(spsr_fast_o) && $stable(spsr_norm_o));
endmodule

bind exc_seq exc_seq_chk #(.AW(AW), .PW(PW), .IRQ_VEC(IRQ_VEC), .FIQ_VEC(FIQ_VEC)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .fiq_req_i(fiq_req_i),
   .instr_done_i(instr_done_i), .ret_i(ret_i), .pc_i(pc_i), .psr_i(psr_i),
   .next_pc_o(next_pc_o), .psr_o(psr_o), .redirect_o(redirect_o),
   .lr_norm_o(lr_norm_o), .spsr_norm_o(spsr_norm_o),
   .lr_fast_o(lr_fast_o), .spsr_fast_o(spsr_fast_o)
);

// File: tb/exc_seq_tb.sv
module exc_seq_tb;
   localparam int AW = 32;
   localparam int PW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 0, fiq = 0, done = 0, ret = 0;
   logic [AW-1:0] pc = '0;
   logic [PW-1:0] psr = '0;
   logic [AW-1:0] next_pc, lr_n, lr_f;
   logic [PW-1:0] psr_out, sp_n, sp_f;
   logic red;

   always #4 clk = ~clk;

   exc_seq u_dut (
      .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .fiq_req_i(fiq),
      .instr_done_i(done), .ret_i(ret), .pc_i(pc), .psr_i(psr),
      .next_pc_o(next_pc), .psr_o(psr_out), .redirect_o(red),
      .lr_norm_o(lr_n), .spsr_norm_o(sp_n), .lr_fast_o(lr_f), .spsr_fast_o(sp_f)
   );

   int checks = 0, errors = 0;
   string cur_req = "R1";
   bit model_on = 0;

   // behavioural reference
   logic [31:0] m_pc, m_psr, m_lrn, m_spn, m_lrf, m_spf;
   logic        m_red;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc <= 0; m_psr <= 32'hD0; m_red <= 0;
         m_lrn <= 0; m_spn <= 0; m_lrf <= 0; m_spf <= 0;
      end else begin
         m_red <= 0;
         if (ret) begin
            if (psr[4:0] == 5'b10010) begin
               m_red <= 1; m_pc <= m_lrn - 4; m_psr <= m_spn;
            end else if (psr[4:0] == 5'b10001) begin
               m_red <= 1; m_pc <= m_lrf - 4; m_psr <= m_spf;
            end
         end else if (done && fiq && !psr[6]) begin
            m_red <= 1; m_pc <= 32'h1C; m_lrf <= pc; m_spf <= psr;
            m_psr <= (psr & ~32'h1F) | 32'hC0 | 32'h11;
         end else if (done && irq && !psr[7]) begin
            m_red <= 1; m_pc <= 32'h18; m_lrn <= pc; m_spn <= psr;
            m_psr <= (psr & ~32'h1F) | 32'h80 | 32'h12;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (model_on) begin
         chk(cur_req, "redirect", {31'b0, red}, {31'b0, m_red});
         chk(cur_req, "next_pc", next_pc, m_pc);
         chk(cur_req, "psr_o", psr_out, m_psr);
         chk("R12", "lr_norm", lr_n, m_lrn);
         chk("R12", "spsr_norm", sp_n, m_spn);
         chk("R12", "lr_fast", lr_f, m_lrf);
         chk("R12", "spsr_fast", sp_f, m_spf);
      end
   end

   task automatic step(input logic i_irq, input logic i_fiq, input logic i_done, input logic i_ret,
                       input logic [31:0] i_pc, input logic [31:0] i_psr);
      irq = i_irq; fiq = i_fiq; done = i_done; ret = i_ret; pc = i_pc; psr = i_psr;
      @(posedge clk); #1;
      irq = 0; fiq = 0; done = 0; ret = 0;
   endtask

   initial begin : watchdog
      #1500000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "redirect", {31'b0, red}, 0);
      chk("R1", "psr_o", psr_out, 32'hD0);
      chk("R1", "next_pc", next_pc, 0);
      chk("R1", "lr_norm", lr_n, 0);
      @(posedge clk); #1;
      model_on = 1;

      // R2 R3 R4 normal entry from user
      cur_req = "R2";
      step(1, 0, 1, 0, 32'h1008, 32'h0000_0010);
      @(negedge clk);
      chk("R2", "lr_norm", lr_n, 32'h1008);
      chk("R3", "psr_o", psr_out, 32'h92);
      chk("R4", "next_pc", next_pc, 32'h18);
      @(posedge clk); #1;
      chk("R4", "redirect one cycle", {31'b0, red}, 0);

      // R8 return from normal mode
      cur_req = "R8";
      step(0, 0, 0, 1, 32'h20, 32'h92);
      @(negedge clk);
      chk("R8", "next_pc", next_pc, 32'h1004);
      chk("R8", "psr_o", psr_out, 32'h10);

      // R5 fast entry
      cur_req = "R5";
      step(0, 1, 1, 0, 32'h2008, 32'h0000_0010);
      @(negedge clk);
      chk("R5", "next_pc", next_pc, 32'h1C);
      chk("R5", "psr_o", psr_out, 32'hD1);
      chk("R12", "lr_norm untouched", lr_n, 32'h1008);

      // R11 return + done + fast request in fast mode: return wins
      cur_req = "R11";
      step(1, 1, 1, 1, 32'h3008, 32'h0000_0011);
      @(negedge clk);
      chk("R11", "next_pc", next_pc, 32'h2004);
      chk("R11", "lr_fast kept", lr_f, 32'h2008);

      // R9 fast return again
      cur_req = "R9";
      step(0, 0, 0, 1, 32'h0, 32'h0000_00D1);
      @(negedge clk);
      chk("R9", "psr_o", psr_out, 32'h10);

      // R6 priority
      cur_req = "R6";
      step(1, 1, 1, 0, 32'h4008, 32'h0000_0010);
      @(negedge clk);
      chk("R6", "fast wins", next_pc, 32'h1C);
      step(1, 1, 1, 0, 32'h5008, 32'h0000_0050);
      @(negedge clk);
      chk("R6", "normal when F set", next_pc, 32'h18);
      chk("R6", "psr_o", psr_out, 32'hD2);

      // R7 masked and off-boundary requests
      cur_req = "R7";
      step(1, 0, 1, 0, 32'h6008, 32'h0000_0090);
      @(negedge clk);
      chk("R7", "masked irq", {31'b0, red}, 0);
      step(1, 1, 0, 0, 32'h6008, 32'h0000_0010);
      @(negedge clk);
      chk("R7", "no boundary", {31'b0, red}, 0);
      chk("R7", "next_pc held", next_pc, 32'h18);

      // R10 return in user mode ignored
      cur_req = "R10";
      step(0, 0, 0, 1, 32'h7008, 32'h0000_0010);
      @(negedge clk);
      chk("R10", "redirect", {31'b0, red}, 0);
      chk("R10", "psr_o held", psr_out, 32'hD2);

      // random traffic against the model
      cur_req = "R12";
      for (int k = 0; k < 400; k++) begin
         logic [31:0] rp;
         logic [2:0]  sel;
         sel = 3'($urandom % 3);
         rp  = ($urandom & 32'hFFFF_FF00) | (($urandom & 3) << 6);
         rp  = rp | ((sel == 0) ? 32'h10 : (sel == 1) ? 32'h11 : 32'h12);
         step(1'($urandom), 1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0),
              $urandom & 32'hFFFF_FFFC, rp);
      end
      @(negedge clk);
      model_on = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule